// File: doc/BRIEF.md
# Burst Mode Trigger Sequencer

This block sits behind a trigger path and cuts the stream of accepted triggers into bursts of a fixed length. Software arms it with a primary enable, which immediately raises a burst busy flag and blocks triggers. Clearing that flag opens a burst. The burst then runs until a programmed number of triggers has been accepted, or until an optional millisecond timeout expires. Either event raises a busy flag again.

With the optional inter-burst mode on, the end of a burst also opens a dead-time window. A third busy flag covers this window. When the window elapses, every busy flag clears by itself and the next burst starts. Software can cut the window short by clearing the inter-burst flag.

The trigger path uses a single inhibit output, which is high whenever any busy flag is set. A built-in prescaler turns the system clock into millisecond ticks. Its phase restarts at every burst start and every burst end, so each timeout is an exact number of clock cycles.

Top module: `burst_gate`

## Requirements
- R1: While `burst_en` is low, all three busy flags and `trig_inhibit` stay 0 in every cycle after reset. Triggers, clear pulses, `bto_en` and `ibto_en` have no effect.
- R2: A cycle where `burst_en` is high after a low cycle sets `busy_burst` at that clock edge and clears the other two flags.
- R3: A burst starts at the clock edge of a cycle where two conditions hold: `busy_ib` is 0, and every flag that is set has its clear input high. At that edge all flags clear and the trigger count restarts from zero.
- R4: During a running burst (all flags 0), the `burst_len`-th accepted trigger sets `busy_burst` at its clock edge. A `burst_len` of 0 means no count limit.
- R5: A `trig_acc` pulse seen while any flag is set, or in the arming cycle, is not counted toward the burst length.
- R6: With `bto_en` high, `busy_bto` is set at the edge that ends the N-th millisecond tick after a burst start. N is `tmo_cfg[15:0]`, and a value of 0 acts as 1. A tick is the CLK_PER_MS-th cycle counted from the start edge, and the count then repeats.
- R7: If the final trigger of a burst and the expiring timeout tick fall in the same cycle, both `busy_burst` and `busy_bto` are set.
- R8: With `ibto_en` high, any burst end also sets `busy_ib`. After N millisecond ticks all flags clear and a new burst starts. N is `tmo_cfg[31:16]`, and a value of 0 acts as 1. Ticks are counted from the end edge.
- R9: A `clr_ib` pulse while `busy_ib` is set starts a new burst at that edge, whatever the other flags are.
- R10: `trig_inhibit` is 1 exactly when at least one busy flag is 1.
- R11: A clear pulse that does not start a burst clears only its own flag and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | Primary burst mode enable |
| bto_en | input | 1 | Burst timeout option enable |
| ibto_en | input | 1 | Inter-burst dead-time option enable |
| burst_len | input | LEN_W | Triggers per burst (0 = unlimited) |
| tmo_cfg | input | 2*TMO_W | [31:16] inter-burst ms, [15:0] burst timeout ms |
| trig_acc | input | 1 | One-cycle pulse per accepted trigger |
| clr_burst | input | 1 | Clear pulse for the burst busy flag |
| clr_bto | input | 1 | Clear pulse for the timeout busy flag |
| clr_ib | input | 1 | Clear pulse for the inter-burst busy flag |
| trig_inhibit | output | 1 | Blocks triggers while any flag is set |
| busy_burst | output | 1 | Burst busy flag |
| busy_bto | output | 1 | Burst timeout busy flag |
| busy_ib | output | 1 | Inter-burst busy flag |

## Verification
The count-based end and the timeout-based end can happen in the same cycle. This happens when the last trigger of a burst arrives exactly on the tick that expires the timeout. The bench provokes this with a one-trigger burst and a one-millisecond timeout, and it places the trigger pulse in the CLK_PER_MS-th cycle after the start edge. Both flags must be set one edge later. A later single clear of the timeout flag must leave the burst flag standing. A behavioural model checks the flags in every cycle, so ticks, ends and restarts falling together are also judged continuously.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef struct packed {
    logic burst;
    logic bto;
    logic ib;
  } busy_t;

  localparam busy_t BUSY_NONE = '{burst: 1'b0, bto: 1'b0, ib: 1'b0};
endpackage

// File: rtl/burst_ms_prescaler.sv
module burst_ms_prescaler #(
  parameter int CLK_PER_MS = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = (cnt_q == LAST);
  assign cnt_en = 1'b1;

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/burst_ms_timer.sv
module burst_ms_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [TMO_W:0]   nxt;
  logic [TMO_W:0]   eff;
  logic             cnt_en;

  assign nxt    = {1'b0, cnt_q} + 1'b1;
  assign eff    = (limit == '0) ? (TMO_W+1)'(1) : {1'b0, limit};
  assign expire = step && (nxt >= eff);
  assign cnt_en = restart || step;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = nxt[TMO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/burst_trig_counter.sv
module burst_trig_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W:0]   nxt;
  logic             cnt_en;

  assign nxt    = {1'b0, cnt_q} + 1'b1;
  assign done   = step && (len != '0) && (nxt == {1'b0, len});
  assign cnt_en = restart || step;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = nxt[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/burst_gate.sv
module burst_gate #(
  parameter int CLK_PER_MS = 40000,
  parameter int LEN_W      = 16,
  parameter int TMO_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               burst_en,
  input  logic               bto_en,
  input  logic               ibto_en,
  input  logic [LEN_W-1:0]   burst_len,
  input  logic [2*TMO_W-1:0] tmo_cfg,
  input  logic               trig_acc,
  input  logic               clr_burst,
  input  logic               clr_bto,
  input  logic               clr_ib,
  output logic               trig_inhibit,
  output logic               busy_burst,
  output logic               busy_bto,
  output logic               busy_ib
);
  import burst_pkg::*;

  localparam int CFG_W = 2 * TMO_W;

  busy_t busy_q, busy_d;
  logic  en_q;

  logic any_busy, arm, running, start;
  logic done, bto_exp, ib_exp, end_evt, tick;
  logic cnt_restart, ib_restart, pre_restart;
  logic [TMO_W-1:0] bto_lim, ib_lim;

  assign bto_lim = tmo_cfg[TMO_W-1:0];
  assign ib_lim  = tmo_cfg[CFG_W-1:TMO_W];

  assign any_busy = busy_q.burst || busy_q.bto || busy_q.ib;
  assign arm      = burst_en && !en_q;
  assign running  = burst_en && en_q && !any_busy;
  assign end_evt  = done || bto_exp;

  // Start: an inter-burst window closes, or software clears what is left.
  always_comb begin
    start = 1'b0;
    if (burst_en && !arm) begin
      if (busy_q.ib)
        start = clr_ib || ib_exp;
      else if (busy_q.burst || busy_q.bto)
        start = (!busy_q.burst || clr_burst) && (!busy_q.bto || clr_bto);
    end
  end

  assign cnt_restart = !burst_en || arm || start;
  assign ib_restart  = !burst_en || end_evt;
  assign pre_restart = cnt_restart || end_evt;

  burst_ms_prescaler #(.CLK_PER_MS(CLK_PER_MS)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(pre_restart), .tick(tick)
  );

  burst_trig_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(cnt_restart),
    .step(running && trig_acc), .len(burst_len), .done(done)
  );

  burst_ms_timer #(.TMO_W(TMO_W)) u_bto (
    .clk(clk), .rst_n(rst_n), .restart(cnt_restart),
    .step(running && bto_en && tick), .limit(bto_lim), .expire(bto_exp)
  );

  burst_ms_timer #(.TMO_W(TMO_W)) u_ibt (
    .clk(clk), .rst_n(rst_n), .restart(ib_restart),
    .step(burst_en && busy_q.ib && ibto_en && tick), .limit(ib_lim),
    .expire(ib_exp)
  );

  always_comb begin
    busy_d = busy_q;
    if (!burst_en) begin
      busy_d = BUSY_NONE;
    end else if (arm) begin
      busy_d = '{burst: 1'b1, bto: 1'b0, ib: 1'b0};
    end else if (start) begin
      busy_d = BUSY_NONE;
    end else if (running && end_evt) begin
      busy_d = '{burst: done, bto: bto_exp, ib: ibto_en};
    end else begin
      busy_d.burst = busy_q.burst && !clr_burst;
      busy_d.bto   = busy_q.bto && !clr_bto;
      busy_d.ib    = busy_q.ib && !clr_ib;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= BUSY_NONE;
      en_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      en_q   <= burst_en;
    end
  end

  assign busy_burst   = busy_q.burst;
  assign busy_bto     = busy_q.bto;
  assign busy_ib      = busy_q.ib;
  assign trig_inhibit = any_busy;
endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic burst_en,
  input logic clr_bto,
  input logic clr_ib,
  input logic trig_inhibit,
  input logic busy_burst,
  input logic busy_bto,
  input logic busy_ib
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> (!busy_burst && !busy_bto && !busy_ib)); // R1

  AST_ARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_en) |=> (busy_burst && !busy_bto && !busy_ib)); // R2

  AST_IB_FORCE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && busy_ib && clr_ib) |=> (!busy_burst && !busy_bto && !busy_ib)); // R9

  AST_IB_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_ib) |-> (busy_burst || busy_bto)); // R8

  AST_BTO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && busy_bto && !busy_ib && !clr_bto) |=> busy_bto); // R11

  AST_IDLE_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_burst && !busy_bto && !busy_ib) |-> !trig_inhibit); // R10

  AST_BUSY_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_burst || busy_bto || busy_ib) |-> trig_inhibit); // R10
endmodule

bind burst_gate burst_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .clr_bto(clr_bto),
  .clr_ib(clr_ib), .trig_inhibit(trig_inhibit), .busy_burst(busy_burst),
  .busy_bto(busy_bto), .busy_ib(busy_ib)
);

// File: tb/test_burst_gate.sv
module test_burst_gate;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_en = 0, bto_en = 0, ibto_en = 0;
  logic [15:0] burst_len = 16'd3;
  logic [31:0] tmo_cfg = 32'd0;
  logic trig_acc = 0, clr_burst = 0, clr_bto = 0, clr_ib = 0;
  logic trig_inhibit, busy_burst, busy_bto, busy_ib;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  burst_gate #(.CLK_PER_MS(P)) i_burst_gate (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .bto_en(bto_en),
    .ibto_en(ibto_en), .burst_len(burst_len), .tmo_cfg(tmo_cfg),
    .trig_acc(trig_acc), .clr_burst(clr_burst), .clr_bto(clr_bto),
    .clr_ib(clr_ib), .trig_inhibit(trig_inhibit), .busy_burst(busy_burst),
    .busy_bto(busy_bto), .busy_ib(busy_ib)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: counts in plain integers.
  bit m_b, m_t, m_i, m_en;
  int m_cnt, m_pre, m_bt, m_it;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_b = 0; m_t = 0; m_i = 0; m_en = 0;
      m_cnt = 0; m_pre = 0; m_bt = 0; m_it = 0;
    end else begin
      bit rise, tk, run, dn, bx, ix, st, ev;
      int bl, il;
      bl = (tmo_cfg[15:0] == 0) ? 1 : int'(tmo_cfg[15:0]);
      il = (tmo_cfg[31:16] == 0) ? 1 : int'(tmo_cfg[31:16]);
      rise = burst_en && !m_en;
      tk   = (m_pre == P - 1);
      run  = burst_en && m_en && !(m_b || m_t || m_i);
      dn   = run && trig_acc && burst_len != 0 && (m_cnt + 1 == int'(burst_len));
      bx   = run && bto_en && tk && (m_bt + 1 >= bl);
      ix   = burst_en && m_i && ibto_en && tk && (m_it + 1 >= il);
      st   = burst_en && !rise &&
             (m_i ? (clr_ib || ix)
                  : ((m_b || m_t) && (!m_b || clr_burst) && (!m_t || clr_bto)));
      ev   = dn || bx;
      if (!burst_en || rise || st) begin m_cnt = 0; m_bt = 0; end
      else begin
        if (run && trig_acc) m_cnt++;
        if (run && bto_en && tk) m_bt++;
      end
      if (!burst_en || ev) m_it = 0;
      else if (m_i && ibto_en && tk) m_it++;
      if (!burst_en || rise || st || ev) m_pre = 0;
      else m_pre = tk ? 0 : m_pre + 1;
      if (!burst_en) begin m_b = 0; m_t = 0; m_i = 0; end
      else if (rise) begin m_b = 1; m_t = 0; m_i = 0; end
      else if (st) begin m_b = 0; m_t = 0; m_i = 0; end
      else if (run && ev) begin m_b = dn; m_t = bx; m_i = ibto_en; end
      else begin
        m_b = m_b && !clr_burst; m_t = m_t && !clr_bto; m_i = m_i && !clr_ib;
      end
      m_en = burst_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 busy_burst vs model", busy_burst, m_b);
      check("R6 busy_bto vs model", busy_bto, m_t);
      check("R8 busy_ib vs model", busy_ib, m_i);
      check("R10 trig_inhibit vs model", trig_inhibit, m_b || m_t || m_i);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig(int n);
    for (int k = 0; k < n; k++) begin
      trig_acc = 1; @(negedge clk); trig_acc = 0; @(negedge clk);
    end
  endtask

  task automatic start_all();
    clr_burst = 1; clr_bto = 1; clr_ib = 1;
    @(negedge clk);
    clr_burst = 0; clr_bto = 0; clr_ib = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    wait_n(3);
    check("R1 reset busy_burst", busy_burst, 0);
    check("R1 reset inhibit", trig_inhibit, 0);
    @(negedge clk); rst_n = 1;
    // R1: disabled block ignores everything
    bto_en = 1; ibto_en = 1;
    pulse_trig(2); start_all(); wait_n(3 * P);
    check("R1 disabled flags", {busy_burst, busy_bto, busy_ib}, 0);
    bto_en = 0; ibto_en = 0;

    // R2 arming
    burst_en = 1; trig_acc = 1; @(negedge clk); trig_acc = 0;
    check("R2 arm busy_burst", busy_burst, 1);
    check("R10 armed inhibit", trig_inhibit, 1);
    pulse_trig(2); // R5: ignored while busy
    clr_burst = 1; @(negedge clk); clr_burst = 0;
    check("R3 start clears busy_burst", busy_burst, 0);
    pulse_trig(2);
    check("R5 only in-burst triggers count", busy_burst, 0);
    pulse_trig(1);
    check("R4 third trigger ends burst", busy_burst, 1);
    pulse_trig(1); start_all(); pulse_trig(2);
    check("R3 count restarts after start", busy_burst, 0);
    pulse_trig(1);
    check("R4 restarted burst ends", busy_burst, 1);

    // R6 burst timeout of 2 ms
    burst_len = 16'd100; bto_en = 1; tmo_cfg = {16'd0, 16'd2};
    start_all(); wait_n(2 * P - 1);
    check("R6 no timeout before 2nd tick", busy_bto, 0);
    wait_n(1);
    check("R6 timeout at 2nd tick", busy_bto, 1);
    check("R6 burst flag untouched", busy_burst, 0);

    // R7 last trigger on the expiring tick
    burst_len = 16'd1; tmo_cfg = {16'd0, 16'd1};
    start_all(); wait_n(P - 1);
    trig_acc = 1; @(negedge clk); trig_acc = 0;
    check("R7 both flags busy_burst", busy_burst, 1);
    check("R7 both flags busy_bto", busy_bto, 1);
    // R11 single clear leaves the other flag
    clr_bto = 1; @(negedge clk); clr_bto = 0;
    check("R11 busy_bto cleared", busy_bto, 0);
    check("R11 busy_burst kept", busy_burst, 1);

    // R8 inter-burst auto restart after 2 ms
    bto_en = 0; ibto_en = 1; burst_len = 16'd2; tmo_cfg = {16'd2, 16'd0};
    start_all(); pulse_trig(1);
    trig_acc = 1; @(negedge clk); trig_acc = 0;
    check("R8 ib set at end", busy_ib, 1);
    wait_n(2 * P - 1);
    check("R8 ib held in window", busy_ib, 1);
    wait_n(1);
    check("R8 auto restart", {busy_burst, busy_bto, busy_ib}, 0);
    pulse_trig(2);
    check("R8 next burst ends", busy_ib, 1);
    // R9 forced restart
    clr_ib = 1; @(negedge clk); clr_ib = 0;
    check("R9 clr_ib starts burst", {busy_burst, busy_bto, busy_ib}, 0);

    // R4 length zero never ends by count
    ibto_en = 0; burst_len = 16'd0;
    pulse_trig(1); start_all(); pulse_trig(5);
    check("R4 zero length unlimited", busy_burst, 0);

    // R1 dropping the enable
    burst_len = 16'd1; pulse_trig(1);
    burst_en = 0; @(negedge clk);
    check("R1 disable clears", {busy_burst, busy_bto, busy_ib}, 0);
    wait_n(2);

    finished = 1;
    summary();
    $finish;
  end
endmodule